// File: doc/BRIEF.md
# Write-Only Serial Command Receiver

This block is the receive side of a two-wire serial slave that sits in front of a dual-channel register controller. It samples the clock and data lines in the system-clock domain. Each line passes through a synchronizer and a persistence filter, and the block then finds the bus start and stop conditions. It compares the incoming 7-bit address against a fixed `0101` prefix followed by three strap pins. It acknowledges a matching address and the bytes that follow, and collects one command byte and one data byte.

A frame is handed downstream only when the stop condition arrives. At that point a one-cycle strobe fires, the command and data outputs are updated, and a flag reports whether both bytes arrived complete. A high eighth address bit requests a no-operation transfer, which touches nothing. Reads, clock stretching and arbitration are not part of the block.

Top module: `i2c_cmd_rx`

## Requirements
- R1: An address byte whose seven upper bits equal `0101` followed by `addr_strap_i[2:1:0]` (MSB first) is acknowledged: `sda_pull_o` is 1 for the whole high phase of the ninth SCL clock.
- R2: An address byte whose upper seven bits do not match is not acknowledged. No later byte of that transfer is acknowledged, and no frame strobe is issued.
- R3: If the eighth address bit is 1 (no-operation), the address is acknowledged, but later bytes are not. No strobe is issued, and `cmd_o` and `data_o` keep their values.
- R4: With the eighth address bit 0, the first and second following bytes are acknowledged and taken MSB first as command and data. They appear on `cmd_o` and `data_o` only in the cycle `frame_valid_o` pulses.
- R5: `frame_valid_o` is a single-cycle pulse issued only on a STOP that ends a matched write transfer.
- R6: `frame_full_o` is 1 with the strobe when both bytes were completely received. A STOP that arrives after the address, after the command only, or inside the data byte gives the strobe with `frame_full_o` = 0, and `cmd_o` carries the command if one was received.
- R7: Bytes that follow the data byte are not acknowledged and do not alter the data that is committed.
- R8: A repeated START inside a frame discards that frame without a strobe and restarts address reception.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_CYCLES` system clocks has no effect on reception.
- R10: After reset, `sda_pull_o`, `frame_valid_o`, `frame_full_o`, `cmd_o` and `data_o` are all 0.
- R11: `sda_pull_o` never changes while the filtered SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| addr_strap_i | input | 3 | Low three address bits |
| frame_valid_o | output | 1 | One-cycle frame commit strobe |
| frame_full_o | output | 1 | Command and data both complete |
| cmd_o | output | 8 | Committed command byte |
| data_o | output | 8 | Committed data byte |

## Verification
The bench uses the default `FILT_CYCLES` = 8 and `SYNC_STAGES` = 2, with the straps tied to `101`. At the 8 ns clock this gives a 64 ns rejection window. A 4-cycle spike injected on either line therefore falls inside the window and can be shown to change nothing, while bus phases of 12 cycles and more pass through. Address matching is exercised against both a wrong strap pattern and a wrong prefix. The cases also cover stops cut short at each byte boundary and inside a byte, surplus bytes, and repeated starts.

// File: rtl/i2c_cmd_rx_pkg.sv
package i2c_cmd_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_TAIL,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (sync_q[SYNC_STAGES-1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
        filt_q <= sync_q[SYNC_STAGES-1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/i2c_bit_shifter.sv
module i2c_bit_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_end_o,
  output logic              ack_end_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (scl_rise_i) begin
      if (cnt_q < CNT_W'(BYTE_W)) shift_q <= {shift_q[BYTE_W-2:0], sda_i};
      if (cnt_q <= CNT_W'(BYTE_W)) cnt_q <= cnt_q + 1'b1;
    end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W + 1)) begin
      cnt_q <= '0;
    end
  end

  assign byte_o     = shift_q;
  assign byte_end_o = scl_fall_i && !clear_i && cnt_q == CNT_W'(BYTE_W);
  assign ack_end_o  = scl_fall_i && !clear_i && cnt_q == CNT_W'(BYTE_W + 1);
endmodule

// File: rtl/i2c_cmd_rx.sv
module i2c_cmd_rx
  import i2c_cmd_rx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_CYCLES = 8,
  parameter int         STRAP_W     = 3,
  parameter logic [3:0] ADDR_PREFIX = 4'b0101
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] addr_strap_i,
  output logic               frame_valid_o,
  output logic               frame_full_o,
  output logic [7:0]         cmd_o,
  output logic [7:0]         data_o
);
  localparam int ADDR_W = 4 + STRAP_W;

  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;

  logic [7:0] rx_byte;
  logic       byte_end, ack_end;

  i2c_bit_shifter #(.BYTE_W(8)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_det | stop_det),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (sda_f),
    .byte_o    (rx_byte),
    .byte_end_o(byte_end),
    .ack_end_o (ack_end)
  );

  rx_state_e  state_q, next_q;
  logic       pull_q, cmd_ok_q, data_ok_q;
  logic [7:0] cmd_sh_q, data_sh_q;
  logic       addr_hit, in_write;

  assign addr_hit = rx_byte[7:1] == ADDR_W'({ADDR_PREFIX, addr_strap_i});
  assign in_write = state_q inside {ST_CMD, ST_DATA, ST_TAIL};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      next_q        <= ST_IDLE;
      pull_q        <= 1'b0;
      cmd_ok_q      <= 1'b0;
      data_ok_q     <= 1'b0;
      cmd_sh_q      <= '0;
      data_sh_q     <= '0;
      frame_valid_o <= 1'b0;
      frame_full_o  <= 1'b0;
      cmd_o         <= '0;
      data_o        <= '0;
    end else begin
      frame_valid_o <= 1'b0;
      if (start_det) begin
        state_q   <= ST_ADDR;
        pull_q    <= 1'b0;
        cmd_ok_q  <= 1'b0;
        data_ok_q <= 1'b0;
      end else if (stop_det) begin
        if (in_write) begin
          frame_valid_o <= 1'b1;
          frame_full_o  <= cmd_ok_q & data_ok_q;
          cmd_o         <= cmd_sh_q;
          data_o        <= data_sh_q;
        end
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (byte_end) begin
        unique case (state_q)
          ST_ADDR: begin
            pull_q <= addr_hit;
            next_q <= (addr_hit && !rx_byte[0]) ? ST_CMD : ST_SKIP;
          end
          ST_CMD: begin
            pull_q   <= 1'b1;
            cmd_sh_q <= rx_byte;
            cmd_ok_q <= 1'b1;
            next_q   <= ST_DATA;
          end
          ST_DATA: begin
            pull_q    <= 1'b1;
            data_sh_q <= rx_byte;
            data_ok_q <= 1'b1;
            next_q    <= ST_TAIL;
          end
          default: begin
            pull_q <= 1'b0;
            next_q <= state_q;
          end
        endcase
      end else if (ack_end) begin
        pull_q <= 1'b0;
        if (state_q != ST_IDLE) state_q <= next_q;
      end
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/i2c_cmd_rx_chk.sv
module i2c_cmd_rx_chk
  import i2c_cmd_rx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      scl_f,
  input logic      scl_q,
  input logic      stop_det,
  input rx_state_e state_q,
  input logic      sda_pull_o,
  input logic      frame_valid_o,
  input logic [7:0] cmd_o,
  input logic [7:0] data_o
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);  // R5

  AST_STROBE_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $past(stop_det));  // R5

  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> ($stable(cmd_o) && $stable(data_o)));  // R4

  AST_PULL_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> (state_q inside {ST_ADDR, ST_CMD, ST_DATA}));  // R2

  AST_PULL_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f && scl_q) |-> $stable(sda_pull_o));  // R11
endmodule

bind i2c_cmd_rx i2c_cmd_rx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_f        (scl_f),
  .scl_q        (scl_q),
  .stop_det     (stop_det),
  .state_q      (state_q),
  .sda_pull_o   (sda_pull_o),
  .frame_valid_o(frame_valid_o),
  .cmd_o        (cmd_o),
  .data_o       (data_o)
);

// File: tb/tb_i2c_cmd_rx.sv
module tb_i2c_cmd_rx;
  localparam int Q = 12;
  localparam int H = 24;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_pull, fv, ff;
  logic [7:0] cmd, data;
  logic sda_line;
  assign sda_line = sda_drv & ~sda_pull;

  always #4 clk = ~clk;

  i2c_cmd_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .addr_strap_i(3'b101),
    .frame_valid_o(fv), .frame_full_o(ff), .cmd_o(cmd), .data_o(data)
  );

  int checks = 0, errors = 0, frames = 0;
  logic last_full;
  logic [7:0] last_cmd, last_data;

  always @(negedge clk) if (fv) begin
    frames++;
    last_full = ff; last_cmd = cmd; last_data = data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; scl_drv = 1'b1; idle(H);
    sda_drv = 1'b0; idle(H);
    scl_drv = 1'b0; idle(Q);
  endtask

  task automatic i2c_rstart();
    sda_drv = 1'b1; idle(Q);
    scl_drv = 1'b1; idle(Q);
    sda_drv = 1'b0; idle(Q);
    scl_drv = 1'b0; idle(Q);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; idle(Q);
    scl_drv = 1'b1; idle(Q);
    sda_drv = 1'b1; idle(H);
  endtask

  // n MSBs, scl ends low; glitch=1 injects 4-cycle spikes on both lines
  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; idle(Q);
      if (glitch) begin scl_drv = 1'b1; idle(4); scl_drv = 1'b0; idle(4); end
      scl_drv = 1'b1; idle(Q);
      if (glitch && !b[i]) begin sda_drv = 1'b1; idle(4); sda_drv = 1'b0; end
      idle(H - Q - (glitch && !b[i] ? 4 : 0));
      scl_drv = 1'b0; idle(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    send_bits(b, 8, glitch);
    sda_drv = 1'b1; idle(Q);
    scl_drv = 1'b1; idle(Q);
    ack = sda_pull;
    idle(H - Q);
    scl_drv = 1'b0; idle(Q);
  endtask

  // {addr7, nop, cmd, data, nbytes, exp_valid, exp_full, exp_ack[2:0]}
  localparam logic [30:0] VECS [7] = '{
    {7'h2D, 1'b0, 8'h11, 8'hA5, 2'd2, 1'b1, 1'b1, 3'b111},
    {7'h2D, 1'b0, 8'h2F, 8'h00, 2'd2, 1'b1, 1'b1, 3'b111},
    {7'h2C, 1'b0, 8'h33, 8'h44, 2'd2, 1'b0, 1'b0, 3'b000},
    {7'h2D, 1'b1, 8'h55, 8'h66, 2'd2, 1'b0, 1'b0, 3'b100},
    {7'h2D, 1'b0, 8'hC3, 8'h00, 2'd1, 1'b1, 1'b0, 3'b110},
    {7'h2D, 1'b0, 8'h00, 8'h00, 2'd0, 1'b1, 1'b0, 3'b100},
    {7'h3D, 1'b0, 8'h77, 8'h88, 2'd2, 1'b0, 1'b0, 3'b000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [2:0] ack_v;
    int f0;
    logic [7:0] pc, pd;
    idle(5);
    // R10: reset state
    chk("R10 pull", 32'(sda_pull), 0);
    chk("R10 strobe", {fv, ff}, 0);
    chk("R10 bytes", {cmd, data}, 0);
    rst_ni = 1'b1; idle(20);

    for (int i = 0; i < 7; i++) begin
      logic [30:0] v;
      v = VECS[i];
      f0 = frames; pc = cmd; pd = data; ack_v = 3'b000;
      i2c_start();
      send_byte(v[30:23], 1'b0, a0); ack_v[2] = a0;
      if (v[6:5] >= 2'd1) begin send_byte(v[22:15], 1'b0, a1); ack_v[1] = a1; end
      if (v[6:5] >= 2'd2) begin send_byte(v[14:7], 1'b0, a2); ack_v[0] = a2; end
      i2c_stop(); idle(40);
      chk("R1/R2/R3 ack pattern", 32'(ack_v), 32'(v[2:0]));
      chk("R5 strobe count", 32'(frames - f0), 32'(v[4]));
      if (v[4]) begin
        chk("R6 full flag", 32'(last_full), 32'(v[3]));
        if (v[6:5] >= 2'd1) chk("R4 cmd", 32'(last_cmd), 32'(v[22:15]));
        if (v[6:5] == 2'd2) chk("R4 data", 32'(last_data), 32'(v[14:7]));
      end else begin
        chk("R2/R3 outputs unchanged", {cmd, data}, {pc, pd});
      end
    end

    // R7: surplus byte not acked, first data kept
    f0 = frames;
    i2c_start();
    send_byte(8'h5A, 1'b0, a0); send_byte(8'h42, 1'b0, a1);
    send_byte(8'h99, 1'b0, a2); send_byte(8'h17, 1'b0, a3);
    i2c_stop(); idle(40);
    chk("R7 surplus ack", 32'(a3), 0);
    chk("R7 frame", {frames - f0, 24'(0)} | {last_data, last_cmd}, {32'(1) << 24} | {8'h99, 8'h42});

    // R6: stop inside data byte
    f0 = frames;
    i2c_start();
    send_byte(8'h5A, 1'b0, a0); send_byte(8'hE1, 1'b0, a1);
    send_bits(8'hF0, 4, 1'b0);
    i2c_stop(); idle(40);
    chk("R6 mid-byte stop strobe", 32'(frames - f0), 1);
    chk("R6 mid-byte stop full", 32'(last_full), 0);
    chk("R6 mid-byte stop cmd", 32'(last_cmd), 32'h E1);

    // R8: repeated start mid data byte aborts first frame
    f0 = frames;
    i2c_start();
    send_byte(8'h5A, 1'b0, a0); send_byte(8'h0C, 1'b0, a1);
    send_bits(8'hAA, 3, 1'b0);
    i2c_rstart();
    send_byte(8'h5A, 1'b0, a0); send_byte(8'h3E, 1'b0, a1); send_byte(8'hB7, 1'b0, a2);
    chk("R8 readdress ack", {a0, a1, a2}, 3'b111);
    i2c_stop(); idle(40);
    chk("R8 single strobe", 32'(frames - f0), 1);
    chk("R8 second frame", {last_cmd, last_data}, {8'h3E, 8'hB7});

    // R9: short spikes on both lines during address byte
    f0 = frames;
    i2c_start();
    send_byte(8'h5A, 1'b1, a0); send_byte(8'h71, 1'b0, a1); send_byte(8'h8E, 1'b0, a2);
    i2c_stop(); idle(40);
    chk("R9 glitch ack", {a0, a1, a2}, 3'b111);
    chk("R9 glitch frame", {frames - f0, 24'(0)} | {last_cmd, last_data}, {32'(1) << 24} | {8'h71, 8'h8E});

    // R10: asynchronous reset clears committed outputs
    rst_ni = 1'b0; idle(3);
    chk("R10 reset outputs", {cmd, data, 7'(0), ff}, 0);
    rst_ni = 1'b1; idle(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule